// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through a small 32-bit register window. Software fills a transmit queue, chooses a word length between 1 and 32 bits, and sets a launch bit. The block then shifts the word out most significant bit first while it shifts the bits it receives into a receive queue. Sticky flags report completion and queue misuse. Writing a one to a flag clears it.

Each launch moves exactly one word. A word's length is independent of the word before it, so software can split longer frames into 32-bit pieces and hold chip select active across them. Chip select can be forced by software onto one of four lines. Serial clock timing comes from a divisor input that sets the half-period in system clocks.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x00A00000, which means only receive-empty (bit 23) and transmit-empty (bit 21) are set. Also after reset, `sck` is low and all four `cs_n` lines are high.
- R2: With command bits [4:0] = N-1, a launch shifts exactly N bits on `mosi`, starting with bit N-1 of the right-aligned transmit word. The command register is at offset 0x00, and bit 31 of it enables the block.
- R3: The receive word collects `miso` bits from the LSB upward, so the first bit received lands at bit N-1. Words leave the receive port (offset 0x180) in the order they arrived.
- R4: The launch bit (command bit 30) clears itself when the shift starts. Busy (status bit 31) is high for the whole shift. Ready (status bit 30) is set when busy drops.
- R5: `sck` idles low. `mosi` changes on falling edges and `miso` is sampled on rising edges. One `sck` period lasts 2*(div_i+1) system clocks.
- R6: When command bit 11 (software select) is 1, command bit 12 drives the line chosen by second-command bits [19:18] (offset 0x04). A value of 1 drives that line low and a value of 0 leaves it high. Every other line stays high.
- R7: A write to the transmit port (offset 0x100) while it holds 4 words is dropped and sets status bit 19. Transmit-full is status bit 20.
- R8: A read of the receive port while it is empty returns 0 and sets status bit 18.
- R9: A launch with the transmit queue empty and transmit enabled (second-command bit 30) sets status bit 24, shifts all zeros, and still completes.
- R10: A word that finishes while the receive queue holds 4 words is dropped and sets status bit 25. Receive is enabled by second-command bit 31.
- R11: Status bits 30, 25, 24, 19 and 18 clear only when a 1 is written to that bit position. Writing 0 to a bit leaves it unchanged.
- R12: The second status word (offset 0x1C) reports the receive queue level in bits [18:16] and the transmit queue level in bits [2:0].
- R13: While command bit 31 is 0, a set launch bit stays pending and no shift starts. The shift begins once the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive port) |
| addr | input | 9 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the access |
| div_i | input | 16 | Serial clock half-period minus one, in system clocks |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench uses the default queue depth of 4, so overflow on both queues can be reached in a few transfers, and so can underrun. It drives `div_i` at 1 for most transfers and at 3 for one transfer, which lets it confirm that the serial clock period scales with the divisor. Word lengths of 1, 5, 8, 13 and 32 bits exercise the single-bit case, the full-word case and odd widths in between. Each length is checked against a behavioural peripheral that captures `mosi` and returns known `miso` patterns.

// File: rtl/spi_reg_master.sv
`timescale 1ns/1ps
module spi_reg_master #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 16,
  parameter int CS_N  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [8:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [CS_N-1:0]  cs_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(CS_N);

  logic en_q, go_q, mst_q, csv_q, css_q, txen_q, rxen_q;
  logic [4:0] len_q;
  logic [SW-1:0] sel_q;
  logic rdy_q, rxovf_q, txunr_q, txovf_q, rxunr_q;
  logic [31:0] txm [DEPTH];
  logic [31:0] rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;
  logic busy_q, sck_q;
  logic [DIV_W-1:0] dcnt;
  logic [4:0] bleft;
  logic [31:0] tsh, rsh;

  wire wr_cmd  = wr_en && addr == 9'h000;
  wire wr_cmd2 = wr_en && addr == 9'h004;
  wire wr_st   = wr_en && addr == 9'h008;
  wire tx_req  = wr_en && addr == 9'h100;
  wire rx_req  = rd_en && addr == 9'h180;

  wire tx_full  = tcnt == CW'(DEPTH);
  wire tx_empty = tcnt == '0;
  wire rx_full  = rcnt == CW'(DEPTH);
  wire rx_empty = rcnt == '0;

  wire launch = en_q && go_q && !busy_q;
  wire tick   = busy_q && dcnt == div_i;
  wire rise   = tick && !sck_q;
  wire fall   = tick && sck_q;
  wire last   = fall && bleft == 5'd0;

  wire tx_push = tx_req && !tx_full;
  wire tx_pop  = launch && txen_q && !tx_empty;
  wire rx_push = last && rxen_q && !rx_full;
  wire rx_pop  = rx_req && !rx_empty;

  wire [31:0] loaded = tx_pop ? (txm[trp] << (5'd31 - len_q)) : 32'd0;

  always_ff @(posedge clk) begin
    if (tx_push) txm[twp] <= wdata;
    if (rx_push) rxm[rwp] <= rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (tx_push) twp <= (twp == AW'(DEPTH - 1)) ? '0 : twp + 1'b1;
      if (tx_pop)  trp <= (trp == AW'(DEPTH - 1)) ? '0 : trp + 1'b1;
      if (rx_push) rwp <= (rwp == AW'(DEPTH - 1)) ? '0 : rwp + 1'b1;
      if (rx_pop)  rrp <= (rrp == AW'(DEPTH - 1)) ? '0 : rrp + 1'b1;
      tcnt <= tcnt + CW'(tx_push) - CW'(tx_pop);
      rcnt <= rcnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sck_q <= 1'b0; dcnt <= '0;
      bleft <= '0; tsh <= '0; rsh <= '0;
    end else if (launch) begin
      busy_q <= 1'b1; sck_q <= 1'b0; dcnt <= '0;
      bleft <= len_q; tsh <= loaded; rsh <= '0;
    end else if (busy_q) begin
      if (tick) begin
        dcnt  <= '0;
        sck_q <= ~sck_q;
        if (rise) rsh <= {rsh[30:0], miso};
        if (fall) begin
          if (bleft == 5'd0) busy_q <= 1'b0;
          else begin
            bleft <= bleft - 5'd1;
            tsh   <= tsh << 1;
          end
        end
      end else dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; go_q <= 1'b0; mst_q <= 1'b0; csv_q <= 1'b0; css_q <= 1'b0;
      len_q <= '0; txen_q <= 1'b0; rxen_q <= 1'b0; sel_q <= '0;
      rdy_q <= 1'b0; rxovf_q <= 1'b0; txunr_q <= 1'b0; txovf_q <= 1'b0; rxunr_q <= 1'b0;
    end else begin
      if (launch) go_q <= 1'b0;
      if (wr_cmd) begin
        en_q <= wdata[31]; go_q <= wdata[30]; mst_q <= wdata[28];
        csv_q <= wdata[12]; css_q <= wdata[11]; len_q <= wdata[4:0];
      end
      if (wr_cmd2) begin
        rxen_q <= wdata[31]; txen_q <= wdata[30]; sel_q <= wdata[18 +: SW];
      end
      if (wr_st && wdata[30]) rdy_q   <= 1'b0;
      if (wr_st && wdata[25]) rxovf_q <= 1'b0;
      if (wr_st && wdata[24]) txunr_q <= 1'b0;
      if (wr_st && wdata[19]) txovf_q <= 1'b0;
      if (wr_st && wdata[18]) rxunr_q <= 1'b0;
      if (last) rdy_q <= 1'b1;
      if (last && rxen_q && rx_full) rxovf_q <= 1'b1;
      if (launch && txen_q && tx_empty) txunr_q <= 1'b1;
      if (tx_req && tx_full) txovf_q <= 1'b1;
      if (rx_req && rx_empty) rxunr_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      9'h000: rdata = {en_q, go_q, 1'b0, mst_q, 15'd0, csv_q, css_q, 6'd0, len_q};
      9'h004: rdata = (32'(rxen_q) << 31) | (32'(txen_q) << 30) | (32'(sel_q) << 18);
      9'h008: rdata = {busy_q, rdy_q, 4'd0, rxovf_q, txunr_q, rx_empty, rx_full,
                       tx_empty, tx_full, txovf_q, rxunr_q, 18'd0};
      9'h01C: rdata = (32'(rcnt) << 16) | 32'(tcnt);
      9'h180: rdata = rx_empty ? 32'd0 : rxm[rrp];
      default: rdata = 32'd0;
    endcase
  end

  wire cs_act = css_q ? csv_q : busy_q;
  always_comb
    for (int i = 0; i < CS_N; i++) cs_n[i] = !(cs_act && sel_q == SW'(i));

  assign sck  = sck_q;
  assign mosi = busy_q ? tsh[31] : 1'b0;

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck);
  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_go_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !go_q);
  assert_ready_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> rdy_q);
  assert_tx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= CW'(DEPTH));
  assert_rx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= CW'(DEPTH));
  assert_no_start_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy_q) |=> !busy_q);
endmodule

// File: tb/spi_reg_master_tb.sv
`timescale 1ns/1ps
module spi_reg_master_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, miso = 0;
  logic [8:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] div_i = 16'd1;
  logic sck, mosi;
  logic [3:0] cs_n;
  int total = 0, fails = 0;
  logic [31:0] exp_q[$];
  logic [31:0] s_word, cap;
  int s_idx = 0;
  longint last_t = 0, per = 0;
  logic [31:0] v;

  localparam logic [31:0] EN = 32'h8000_0000, GO = 32'h4000_0000, MST = 32'h1000_0000,
                          CSV = 32'h0000_1000, CSS = 32'h0000_0800;

  always #2 clk = ~clk;

  spi_reg_master dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .div_i(div_i), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n));

  always @(negedge sck) if (s_idx > 0) begin s_idx = s_idx - 1; miso = s_word[s_idx]; end
  always @(posedge sck) begin
    cap = {cap[30:0], mosi};
    per = $time - last_t; last_t = $time;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_rdy();
    for (int k = 0; k < 2000; k++) begin
      rd(9'h008, v);
      if (v[30]) break;
    end
  endtask

  task automatic rx_monitor(string req);
    logic [31:0] e;
    rd(9'h180, v);
    e = exp_q.pop_front();
    check(req, v, e);
  endtask

  task automatic xfer(int n, bit push, logic [31:0] d, logic [31:0] exp_mosi,
                      logic [31:0] slv, bit expect_rx);
    logic [31:0] m, base;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    base = EN | MST | CSS | CSV | 32'(n - 1);
    wr(9'h000, base);
    if (push) wr(9'h100, d);
    s_word = slv; s_idx = n - 1; miso = slv[n-1]; cap = 0;
    wr(9'h000, base | GO);
    wait_rdy();
    check("R2 mosi bits", cap & m, exp_mosi & m);
    wr(9'h008, 32'h4000_0000);
    if (expect_rx) exp_q.push_back(slv & m);
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(9'h008, v);
    check("R1 status", v, 32'h00A0_0000);
    check("R1 sck/cs", {27'd0, sck, cs_n}, 32'h0000_000F);

    wr(9'h004, 32'hC000_0000 | (32'd2 << 18));
    wr(9'h000, CSS | CSV);
    check("R6 cs active", {28'd0, cs_n}, 32'h0000_000B);
    wr(9'h000, CSS);
    check("R6 cs released", {28'd0, cs_n}, 32'h0000_000F);

    wr(9'h000, EN | MST | CSS | CSV | 32'd7);
    wr(9'h100, 32'h0000_00A5);
    s_word = 32'h3C; s_idx = 7; miso = 1'b0; cap = 0;
    wr(9'h000, EN | MST | CSS | CSV | 32'd7 | GO);
    rd(9'h000, v);
    check("R4 go self-clear", {31'd0, v[30]}, 32'd0);
    rd(9'h008, v);
    check("R4 busy", {31'd0, v[31]}, 32'd1);
    check("R6 cs during shift", {28'd0, cs_n}, 32'h0000_000B);
    wait_rdy();
    check("R4 ready set, busy clear", {30'd0, v[31:30]}, 32'd1);
    check("R2 mosi 8 bits", cap & 32'hFF, 32'hA5);
    check("R5 period div1", 32'(per), 32'd16);
    wr(9'h008, 32'h4000_0000);
    rd(9'h008, v);
    check("R11 ready cleared", {31'd0, v[30]}, 32'd0);
    exp_q.push_back(32'h3C);

    xfer(32, 1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h1234_5678, 1);
    xfer(1, 1, 32'h1, 32'h1, 32'h1, 1);
    xfer(13, 1, 32'h1ABC, 32'h1ABC, 32'h0F0F, 1);
    rd(9'h01C, v);
    check("R12 rx level", v, 32'h0004_0000);
    xfer(5, 1, 32'h15, 32'h15, 32'h0A, 0);
    rd(9'h008, v);
    check("R10 rx overflow flag", {31'd0, v[25]}, 32'd1);
    rd(9'h01C, v);
    check("R10 rx level held", v, 32'h0004_0000);

    for (int i = 0; i < 4; i++) rx_monitor("R3 rx word");
    rd(9'h180, v);
    check("R8 empty read value", v, 32'd0);
    rd(9'h008, v);
    check("R8 rx underrun flag", {31'd0, v[18]}, 32'd1);

    wr(9'h008, 32'd0);
    rd(9'h008, v);
    check("R11 zero write keeps flags", {30'd0, v[25], v[18]}, 32'd3);
    wr(9'h008, 32'h0004_0000);
    rd(9'h008, v);
    check("R11 selective clear", {30'd0, v[25], v[18]}, 32'd2);
    wr(9'h008, 32'h0200_0000);

    for (int i = 1; i <= 5; i++) wr(9'h100, 32'(i * 32'h11));
    rd(9'h008, v);
    check("R7 tx full and overflow", {30'd0, v[20], v[19]}, 32'd3);
    rd(9'h01C, v);
    check("R12 tx level", v, 32'h0000_0004);
    xfer(8, 0, 0, 32'h11, 32'h81, 1);
    xfer(8, 0, 0, 32'h22, 32'h42, 1);
    xfer(8, 0, 0, 32'h33, 32'h24, 1);
    xfer(8, 0, 0, 32'h44, 32'h18, 1);
    for (int i = 0; i < 4; i++) rx_monitor("R7 drained order");

    xfer(6, 0, 0, 32'h0, 32'h2D, 1);
    rd(9'h008, v);
    check("R9 tx underrun flag", {31'd0, v[24]}, 32'd1);
    rx_monitor("R9 rx still captured");
    wr(9'h008, 32'h0108_0000);

    wr(9'h100, 32'h0000_0096);
    wr(9'h000, MST | CSS | CSV | 32'd7 | GO);
    repeat (20) @(negedge clk);
    rd(9'h008, v);
    check("R13 no start when disabled", {30'd0, v[31:30]}, 32'd0);
    rd(9'h000, v);
    check("R13 launch pending", {31'd0, v[30]}, 32'd1);
    div_i = 16'd3;
    s_word = 32'h69; s_idx = 7; miso = 1'b0; cap = 0;
    wr(9'h000, EN | MST | CSS | CSV | 32'd7 | GO);
    wait_rdy();
    check("R13 runs after enable", cap & 32'hFF, 32'h96);
    check("R5 period div3", 32'(per), 32'd32);
    exp_q.push_back(32'h69);
    rx_monitor("R3 rx after enable");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule